// File: doc/BRIEF.md
# Prioritized Interrupt Dispatch Controller

This block decides, one request at a time, whether a pending interrupt is accepted by the processor, and produces every piece of state that accepting it changes. Each request carries the interrupt level, the raised and enabled line vectors, a per-level line mask table, the current status word, the current program counter and the vector base. The block qualifies the level against the current status and the line masks. On a take it issues a one-cycle pulse and, on that same clock edge, writes the new status word, the per-level saved PC and saved status registers, the double-fault PC register, the exception cause, the exception kind and the next PC.

Levels above one are high-priority: each has its own save registers and vector, and entry raises the status level field to the taken level. Level one is folded into the general exception path instead. It records a fixed cause code and sorts the entry into kernel, user or double-fault by the exception-mode and user-mode status bits. Vector addresses may be relocated relative to a software-set base. A vector configured as zero suppresses the redirect.

Top module: `irq_dispatch`

## Requirements
- R1: A synchronous, active-high reset clears `taken`, `redirect`, `next_pc`, `kind_out` (0 = none), `cause_out`, `depc_out` and all saved registers, and clears `status_out`, so its interrupt-level field reads zero.
- R2: `taken` is high for exactly the one cycle after an edge that sampled `req_valid` high with all three of these true. First, `req_level` is greater than the status level field `status_in[3:0]`. Second, `req_level` is at most `NV`. Third, the mask for that level (`lvl_mask[(L-1)*NL +: NL]`) ANDed with `raised` and `enabled` has a bit set. Otherwise `taken` is low.
- R3: On a take at level L > 1, the saved PC for L (`epc_out[(L-1)*AW +: AW]`) receives `pc_in` and the saved status for L (`eps_out[(L-1)*SW +: SW]`) receives `status_in`. `status_out` becomes `status_in` with bits [3:0] set to L and exception-mode bit 4 set. `kind_out` becomes 0.
- R4: A take at level 1 writes `cause_out` with `L1_CAUSE`. A take at a higher level leaves `cause_out` unchanged.
- R5: A level-1 take with status bit 4 set gives `kind_out` = 3 (double). The PC goes to `depc_out` when `HAS_DEPC` is nonzero, and otherwise to the level-1 saved PC.
- R6: A level-1 take with status bit 4 clear stores the PC in the level-1 saved PC. `kind_out` becomes 2 (user) if status bit 5 is set, and 1 (kernel) otherwise.
- R7: After any level-1 take, `status_out` equals `status_in` with bit 4 set and all other bits unchanged.
- R8: The raw vector is `INT_VEC_BASE + L*INT_VEC_STRIDE` for level L > 1, and `KERNEL_VEC`, `USER_VEC` or `DOUBLE_VEC` for the level-1 kinds. With `RELOC` nonzero, `next_pc` is raw − `RESET_BASE` + `vec_base`; with `RELOC` zero it is the raw vector.
- R9: When the selected raw vector is zero, `redirect` is low and `next_pc` equals the `pc_in` of the take. Otherwise `redirect` is high.
- R10: In a cycle without a take, `status_out`, `cause_out`, `kind_out`, `redirect`, `next_pc`, `depc_out` and all saved registers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | A pending interrupt is offered this cycle |
| req_level | input | LVL_W | Level of the pending interrupt |
| raised | input | NL | Raised interrupt lines |
| enabled | input | NL | Enabled interrupt lines |
| lvl_mask | input | NV*NL | Line mask per level, level L at bits (L-1)*NL |
| status_in | input | SW | Current status: [3:0] level, [4] exception mode, [5] user mode |
| pc_in | input | AW | Current program counter |
| vec_base | input | AW | Vector base used for relocation |
| taken | output | 1 | One-cycle pulse: interrupt accepted |
| status_out | output | SW | Updated status word |
| epc_out | output | NV*AW | Saved PC per level, level L at bits (L-1)*AW |
| eps_out | output | NV*SW | Saved status per level, level 1 slot reads zero |
| depc_out | output | AW | Double-fault saved PC |
| cause_out | output | CW | Exception cause |
| kind_out | output | 2 | 0 none, 1 kernel, 2 user, 3 double |
| redirect | output | 1 | Next PC is a vector |
| next_pc | output | AW | Next program counter |

## Verification
Every result of a take is due on the first rising edge after the request is presented. This includes the pulse, the status word, the save registers, the cause, the kind and the next PC. None is visible before that edge. The bench drives a request on a falling edge, lets one rising edge pass and compares every output on the following falling edge. It then presents the next request at once, so each comparison also checks that a non-take cycle left the previous state untouched. The sweep covers all levels, all current levels, all four mode-bit combinations and all raised patterns under two enable patterns. It runs on two instances: one with the double-fault register and relocation, and one without either.

// File: rtl/irq_dispatch_pkg.sv
package irq_dispatch_pkg;

   // status word field positions (a neighbouring pipeline decodes these)
   localparam int ST_LVL_W   = 4;
   localparam int ST_EXCM    = 4;
   localparam int ST_USER    = 5;
   localparam int ST_MIN_W   = 6;
   localparam int MAX_LEVELS = 7;
   localparam int MAX_LINES  = 32;

   typedef enum logic [1:0] {
      KIND_NONE   = 2'd0,
      KIND_KERNEL = 2'd1,
      KIND_USER   = 2'd2,
      KIND_DOUBLE = 2'd3
   } exc_kind_e;

endpackage

// File: rtl/irq_qualify.sv
module irq_qualify #(
   parameter int NL    = 32,
   parameter int NV    = 7,
   parameter int LVL_W = 3
) (
   input  logic [LVL_W-1:0] req_level,
   input  logic [3:0]       cur_level,
   input  logic [NL-1:0]    raised,
   input  logic [NL-1:0]    enabled,
   input  logic [NV*NL-1:0] lvl_mask,
   output logic             qualified,
   output logic             is_high
);

   logic [NL-1:0] sel_mask;
   logic          in_range;
   logic          above_cur;

   always_comb begin
      sel_mask = '0;
      for (int l = 1; l <= NV; l++) begin
         if (32'(req_level) == l) sel_mask = lvl_mask[(l-1)*NL +: NL];
      end
   end

   always_comb begin
      in_range  = (req_level != '0) && (32'(req_level) <= NV);
      above_cur = 32'(req_level) > 32'(cur_level);
      qualified = in_range && above_cur && (|(sel_mask & raised & enabled));
      is_high   = 32'(req_level) > 1;
   end

endmodule

// File: rtl/irq_vector_map.sv
module irq_vector_map
   import irq_dispatch_pkg::*;
#(
   parameter int             NV             = 7,
   parameter int             AW             = 32,
   parameter int             LVL_W          = 3,
   parameter bit             RELOC          = 1'b1,
   parameter logic [AW-1:0]  RESET_BASE     = 32'h4000_0000,
   parameter logic [AW-1:0]  INT_VEC_BASE   = 32'h4000_0100,
   parameter logic [AW-1:0]  INT_VEC_STRIDE = 32'h0000_0040,
   parameter logic [AW-1:0]  KERNEL_VEC     = 32'h4000_0300,
   parameter logic [AW-1:0]  USER_VEC       = 32'h4000_0340,
   parameter logic [AW-1:0]  DOUBLE_VEC     = 32'h4000_03c0
) (
   input  logic             is_high,
   input  logic [LVL_W-1:0] level,
   input  exc_kind_e        kind,
   input  logic [AW-1:0]    pc,
   input  logic [AW-1:0]    vec_base,
   output logic             redirect,
   output logic [AW-1:0]    next_pc
);

   logic [AW-1:0] raw_vec;
   logic [AW-1:0] moved_vec;

   always_comb begin
      if (is_high) begin
         raw_vec = INT_VEC_BASE + (AW'(level) * INT_VEC_STRIDE);
      end else begin
         case (kind)
            KIND_KERNEL: raw_vec = KERNEL_VEC;
            KIND_USER:   raw_vec = USER_VEC;
            KIND_DOUBLE: raw_vec = DOUBLE_VEC;
            default:     raw_vec = '0;
         endcase
      end
   end

   generate
      if (RELOC) begin : g_reloc
         assign moved_vec = raw_vec - RESET_BASE + vec_base;
      end else begin : g_fixed
         assign moved_vec = raw_vec;
      end
   endgenerate

   assign redirect = (raw_vec != '0);
   assign next_pc  = redirect ? moved_vec : pc;

endmodule

// File: rtl/irq_context_regs.sv
module irq_context_regs #(
   parameter int NV       = 7,
   parameter int AW       = 32,
   parameter int SW       = 8,
   parameter int LVL_W    = 3,
   parameter bit HAS_DEPC = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             save_en,
   input  logic [LVL_W-1:0] save_level,
   input  logic             save_double,
   input  logic [AW-1:0]    save_pc,
   input  logic [SW-1:0]    save_status,
   output logic [NV*AW-1:0] epc_flat,
   output logic [NV*SW-1:0] eps_flat,
   output logic [AW-1:0]    depc
);

   logic dbl_to_depc;

   generate
      if (HAS_DEPC) begin : g_depc
         logic [AW-1:0] depc_q;
         assign dbl_to_depc = save_double;
         always_ff @(posedge clk) begin
            if (rst)                         depc_q <= '0;
            else if (save_en && save_double) depc_q <= save_pc;
         end
         assign depc = depc_q;
      end else begin : g_no_depc
         assign dbl_to_depc = 1'b0;
         assign depc        = '0;
      end

      for (genvar l = 1; l <= NV; l++) begin : g_lvl
         logic [AW-1:0] epc_q;
         logic          wr_pc;
         assign wr_pc = save_en && (save_level == LVL_W'(l)) &&
                        !((l == 1) && dbl_to_depc);
         always_ff @(posedge clk) begin
            if (rst)        epc_q <= '0;
            else if (wr_pc) epc_q <= save_pc;
         end
         assign epc_flat[(l-1)*AW +: AW] = epc_q;

         if (l == 1) begin : g_eps_none
            assign eps_flat[0 +: SW] = '0;
         end else begin : g_eps
            logic [SW-1:0] eps_q;
            always_ff @(posedge clk) begin
               if (rst) eps_q <= '0;
               else if (save_en && (save_level == LVL_W'(l))) eps_q <= save_status;
            end
            assign eps_flat[(l-1)*SW +: SW] = eps_q;
         end
      end
   endgenerate

endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch
   import irq_dispatch_pkg::*;
#(
   parameter int             NL             = 32,
   parameter int             NV             = 7,
   parameter int             AW             = 32,
   parameter int             SW             = 8,
   parameter int             CW             = 6,
   parameter bit             HAS_DEPC       = 1'b1,
   parameter bit             RELOC          = 1'b1,
   parameter logic [CW-1:0]  L1_CAUSE       = 6'd4,
   parameter logic [AW-1:0]  RESET_BASE     = 32'h4000_0000,
   parameter logic [AW-1:0]  INT_VEC_BASE   = 32'h4000_0100,
   parameter logic [AW-1:0]  INT_VEC_STRIDE = 32'h0000_0040,
   parameter logic [AW-1:0]  KERNEL_VEC     = 32'h4000_0300,
   parameter logic [AW-1:0]  USER_VEC       = 32'h4000_0340,
   parameter logic [AW-1:0]  DOUBLE_VEC     = 32'h4000_03c0,
   localparam int            LVL_W          = $clog2(NV + 1)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             req_valid,
   input  logic [LVL_W-1:0] req_level,
   input  logic [NL-1:0]    raised,
   input  logic [NL-1:0]    enabled,
   input  logic [NV*NL-1:0] lvl_mask,
   input  logic [SW-1:0]    status_in,
   input  logic [AW-1:0]    pc_in,
   input  logic [AW-1:0]    vec_base,
   output logic             taken,
   output logic [SW-1:0]    status_out,
   output logic [NV*AW-1:0] epc_out,
   output logic [NV*SW-1:0] eps_out,
   output logic [AW-1:0]    depc_out,
   output logic [CW-1:0]    cause_out,
   output logic [1:0]       kind_out,
   output logic             redirect,
   output logic [AW-1:0]    next_pc
);

   // elaboration-time parameter checks
   generate
      if (NV < 1 || NV > MAX_LEVELS) begin : g_bad_nv
         $error("irq_dispatch: NV must lie in 1..7");
      end
      if (NL < 1 || NL > MAX_LINES) begin : g_bad_nl
         $error("irq_dispatch: NL must lie in 1..32");
      end
      if (SW < ST_MIN_W) begin : g_bad_sw
         $error("irq_dispatch: SW too narrow for the status fields");
      end
      if (AW < 8) begin : g_bad_aw
         $error("irq_dispatch: AW too narrow");
      end
   endgenerate

   logic          qualified;
   logic          is_high;
   logic          hit;
   logic          excm_now;
   logic          user_now;
   exc_kind_e     kind_nx;
   logic [SW-1:0] status_nx;
   logic          redirect_nx;
   logic [AW-1:0] next_pc_nx;

   irq_qualify #(
      .NL    (NL),
      .NV    (NV),
      .LVL_W (LVL_W)
   ) u_qualify (
      .req_level (req_level),
      .cur_level (status_in[ST_LVL_W-1:0]),
      .raised    (raised),
      .enabled   (enabled),
      .lvl_mask  (lvl_mask),
      .qualified (qualified),
      .is_high   (is_high)
   );

   assign hit      = req_valid && qualified;
   assign excm_now = status_in[ST_EXCM];
   assign user_now = status_in[ST_USER];

   always_comb begin
      if (is_high)       kind_nx = KIND_NONE;
      else if (excm_now) kind_nx = KIND_DOUBLE;
      else if (user_now) kind_nx = KIND_USER;
      else               kind_nx = KIND_KERNEL;
   end

   always_comb begin
      status_nx = status_in;
      status_nx[ST_EXCM] = 1'b1;
      if (is_high) status_nx[ST_LVL_W-1:0] = ST_LVL_W'(req_level);
   end

   irq_vector_map #(
      .NV             (NV),
      .AW             (AW),
      .LVL_W          (LVL_W),
      .RELOC          (RELOC),
      .RESET_BASE     (RESET_BASE),
      .INT_VEC_BASE   (INT_VEC_BASE),
      .INT_VEC_STRIDE (INT_VEC_STRIDE),
      .KERNEL_VEC     (KERNEL_VEC),
      .USER_VEC       (USER_VEC),
      .DOUBLE_VEC     (DOUBLE_VEC)
   ) u_vecmap (
      .is_high  (is_high),
      .level    (req_level),
      .kind     (kind_nx),
      .pc       (pc_in),
      .vec_base (vec_base),
      .redirect (redirect_nx),
      .next_pc  (next_pc_nx)
   );

   irq_context_regs #(
      .NV       (NV),
      .AW       (AW),
      .SW       (SW),
      .LVL_W    (LVL_W),
      .HAS_DEPC (HAS_DEPC)
   ) u_ctx (
      .clk         (clk),
      .rst         (rst),
      .save_en     (hit),
      .save_level  (req_level),
      .save_double (!is_high && excm_now),
      .save_pc     (pc_in),
      .save_status (status_in),
      .epc_flat    (epc_out),
      .eps_flat    (eps_out),
      .depc        (depc_out)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         taken      <= 1'b0;
         status_out <= '0;
         cause_out  <= '0;
         kind_out   <= KIND_NONE;
         redirect   <= 1'b0;
         next_pc    <= '0;
      end else begin
         taken <= hit;
         if (hit) begin
            status_out <= status_nx;
            kind_out   <= kind_nx;
            redirect   <= redirect_nx;
            next_pc    <= next_pc_nx;
            if (!is_high) cause_out <= L1_CAUSE;
         end
      end
   end

endmodule

// File: rtl/irq_dispatch_chk.sv
module irq_dispatch_chk #(
   parameter int NV = 7,
   parameter int AW = 32,
   parameter int SW = 8,
   parameter int CW = 6
) (
   input logic             clk,
   input logic             rst,
   input logic             req_valid,
   input logic [SW-1:0]    status_in,
   input logic [AW-1:0]    pc_in,
   input logic             taken,
   input logic [SW-1:0]    status_out,
   input logic [NV*AW-1:0] epc_out,
   input logic [NV*SW-1:0] eps_out,
   input logic [AW-1:0]    depc_out,
   input logic [CW-1:0]    cause_out,
   input logic [1:0]       kind_out,
   input logic             redirect,
   input logic [AW-1:0]    next_pc
);

   assert_take_needs_req_R2: assert property (@(posedge clk) disable iff (rst)
      taken |-> $past(req_valid));

   assert_high_level_raised_R3: assert property (@(posedge clk) disable iff (rst)
      (taken && kind_out == 2'd0) |-> (status_out[3:0] > $past(status_in[3:0])));

   assert_double_from_excm_R5: assert property (@(posedge clk) disable iff (rst)
      (taken && kind_out == 2'd3) |-> $past(status_in[4]));

   assert_user_kind_R6: assert property (@(posedge clk) disable iff (rst)
      (taken && kind_out == 2'd2) |-> ($past(status_in[5]) && !$past(status_in[4])));

   assert_excm_set_R7: assert property (@(posedge clk) disable iff (rst)
      taken |-> status_out[4]);

   assert_no_redirect_pc_R9: assert property (@(posedge clk) disable iff (rst)
      (taken && !redirect) |-> (next_pc == $past(pc_in)));

   assert_hold_when_idle_R10: assert property (@(posedge clk) disable iff (rst)
      !taken |-> ($stable(epc_out) && $stable(eps_out) && $stable(depc_out) &&
                  $stable(status_out) && $stable(cause_out) && $stable(next_pc)));

endmodule

bind irq_dispatch irq_dispatch_chk #(
   .NV (NV),
   .AW (AW),
   .SW (SW),
   .CW (CW)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .req_valid  (req_valid),
   .status_in  (status_in),
   .pc_in      (pc_in),
   .taken      (taken),
   .status_out (status_out),
   .epc_out    (epc_out),
   .eps_out    (eps_out),
   .depc_out   (depc_out),
   .cause_out  (cause_out),
   .kind_out   (kind_out),
   .redirect   (redirect),
   .next_pc    (next_pc)
);

// File: tb/irq_dispatch_tb.sv
module irq_dispatch_tb;

   localparam int NL = 4;
   localparam int NV = 7;
   localparam int AW = 32;
   localparam int SW = 8;
   localparam int CW = 6;
   localparam int LVL_W = 3;
   localparam logic [AW-1:0] RB   = 32'h4000_0000;
   localparam logic [AW-1:0] IVB  = 32'h4000_0100;
   localparam logic [AW-1:0] IVS  = 32'h0000_0040;
   localparam logic [AW-1:0] KVEC = 32'h4000_0300;
   localparam logic [AW-1:0] UVEC = 32'h4000_0340;
   localparam logic [AW-1:0] DVEC = 32'h0000_0000;
   localparam logic [CW-1:0] L1C  = 6'd4;

   logic             clk = 1'b0;
   logic             rst;
   logic             req_valid;
   logic [LVL_W-1:0] req_level;
   logic [NL-1:0]    raised;
   logic [NL-1:0]    enabled;
   logic [NV*NL-1:0] lvl_mask;
   logic [SW-1:0]    status_in;
   logic [AW-1:0]    pc_in;
   logic [AW-1:0]    vec_base;

   logic             taken    [2];
   logic [SW-1:0]    st_o     [2];
   logic [NV*AW-1:0] epc_o    [2];
   logic [NV*SW-1:0] eps_o    [2];
   logic [AW-1:0]    depc_o   [2];
   logic [CW-1:0]    cause_o  [2];
   logic [1:0]       kind_o   [2];
   logic             redir_o  [2];
   logic [AW-1:0]    npc_o    [2];

   always #10 clk = ~clk;

   irq_dispatch #(
      .NL(NL), .NV(NV), .AW(AW), .SW(SW), .CW(CW),
      .HAS_DEPC(1'b1), .RELOC(1'b1), .L1_CAUSE(L1C), .RESET_BASE(RB),
      .INT_VEC_BASE(IVB), .INT_VEC_STRIDE(IVS),
      .KERNEL_VEC(KVEC), .USER_VEC(UVEC), .DOUBLE_VEC(DVEC)
   ) u_dut (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_level(req_level),
      .raised(raised), .enabled(enabled), .lvl_mask(lvl_mask),
      .status_in(status_in), .pc_in(pc_in), .vec_base(vec_base),
      .taken(taken[0]), .status_out(st_o[0]), .epc_out(epc_o[0]),
      .eps_out(eps_o[0]), .depc_out(depc_o[0]), .cause_out(cause_o[0]),
      .kind_out(kind_o[0]), .redirect(redir_o[0]), .next_pc(npc_o[0])
   );

   irq_dispatch #(
      .NL(NL), .NV(NV), .AW(AW), .SW(SW), .CW(CW),
      .HAS_DEPC(1'b0), .RELOC(1'b0), .L1_CAUSE(L1C), .RESET_BASE(RB),
      .INT_VEC_BASE(IVB), .INT_VEC_STRIDE(IVS),
      .KERNEL_VEC(KVEC), .USER_VEC(UVEC), .DOUBLE_VEC(DVEC)
   ) u_dut_plain (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_level(req_level),
      .raised(raised), .enabled(enabled), .lvl_mask(lvl_mask),
      .status_in(status_in), .pc_in(pc_in), .vec_base(vec_base),
      .taken(taken[1]), .status_out(st_o[1]), .epc_out(epc_o[1]),
      .eps_out(eps_o[1]), .depc_out(depc_o[1]), .cause_out(cause_o[1]),
      .kind_out(kind_o[1]), .redirect(redir_o[1]), .next_pc(npc_o[1])
   );

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   // expected model state, one set per instance
   logic [NV*AW-1:0] x_epc   [2];
   logic [NV*SW-1:0] x_eps   [2];
   logic [AW-1:0]    x_depc  [2];
   logic [SW-1:0]    x_st    [2];
   logic [CW-1:0]    x_cause [2];
   logic [1:0]       x_kind  [2];
   logic             x_redir [2];
   logic [AW-1:0]    x_npc   [2];

   task automatic chk(input string tag, input string what,
                      input logic [255:0] act, input logic [255:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   function automatic logic [NL-1:0] mask_of(input int l);
      logic [NL-1:0] m;
      m = NL'(1) << ((l - 1) % NL);
      if (l == 7) m = m | 4'b1000;
      return m;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fails++;
         $display("FAIL R2 watchdog actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      for (int l = 1; l <= NV; l++) lvl_mask[(l-1)*NL +: NL] = mask_of(l);
      rst       = 1'b1;
      req_valid = 1'b1;
      req_level = 3'd5;
      raised    = '1;
      enabled   = '1;
      status_in = 8'h00;
      pc_in     = 32'h1234_5678;
      vec_base  = 32'h8000_0000;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset state even with a qualifying request present
      for (int i = 0; i < 2; i++) begin
         chk("R1", "taken",  256'(taken[i]),   256'(0));
         chk("R1", "status", 256'(st_o[i]),    256'(0));
         chk("R1", "kind",   256'(kind_o[i]),  256'(0));
         chk("R1", "redir",  256'(redir_o[i]), 256'(0));
         chk("R1", "npc",    256'(npc_o[i]),   256'(0));
         chk("R1", "epc",    256'(epc_o[i]),   256'(0));
         chk("R1", "eps",    256'(eps_o[i]),   256'(0));
         chk("R1", "depc",   256'(depc_o[i]),  256'(0));
         chk("R1", "cause",  256'(cause_o[i]), 256'(0));
         x_epc[i] = '0; x_eps[i] = '0; x_depc[i] = '0; x_st[i] = '0;
         x_cause[i] = '0; x_kind[i] = '0; x_redir[i] = 1'b0; x_npc[i] = '0;
      end
      req_valid = 1'b0;
      rst = 1'b0;

      begin
         int trial;
         trial = 0;
         for (int lv = 0; lv < 8; lv++)
         for (int cl = 0; cl < 8; cl++)
         for (int sm = 0; sm < 4; sm++)
         for (int r = 0; r < 16; r++)
         for (int ev = 0; ev < 2; ev++) begin
            logic        qual;
            logic [3:0]  en;
            logic [SW-1:0] st;
            logic [AW-1:0] vec;
            string       tg;
            en = (ev == 0) ? 4'hF : ({r[0], r[3:1]} ^ 4'h5);
            st = {2'(trial), 1'(sm >> 1), 1'(sm), 4'(cl)};
            req_valid = ((trial % 7) != 3);
            req_level = 3'(lv);
            raised    = 4'(r);
            enabled   = en;
            status_in = st;
            pc_in     = 32'h1000_0000 + 32'(trial) * 4;
            vec_base  = 32'h8000_0000 + (32'(trial) << 8);
            @(posedge clk);
            @(negedge clk);

            qual = req_valid && (lv > cl) && (lv >= 1) && (lv <= NV) &&
                   (|(mask_of((lv < 1) ? 1 : lv) & 4'(r) & en));
            for (int i = 0; i < 2; i++) begin
               if (qual) begin
                  if (lv > 1) begin
                     x_epc[i][(lv-1)*AW +: AW] = pc_in;
                     x_eps[i][(lv-1)*SW +: SW] = st;
                     x_st[i]   = (st & 8'hF0) | 8'(lv) | 8'h10;
                     x_kind[i] = 2'd0;
                     vec = IVB + 32'(lv) * IVS;
                  end else begin
                     x_cause[i] = L1C;
                     if (st[4]) begin
                        x_kind[i] = 2'd3;
                        if (i == 0) x_depc[i] = pc_in;
                        else        x_epc[i][0 +: AW] = pc_in;
                        vec = DVEC;
                     end else begin
                        x_epc[i][0 +: AW] = pc_in;
                        x_kind[i] = st[5] ? 2'd2 : 2'd1;
                        vec = st[5] ? UVEC : KVEC;
                     end
                     x_st[i] = st | 8'h10;
                  end
                  x_redir[i] = (vec != 0);
                  if (vec == 0)    x_npc[i] = pc_in;
                  else if (i == 0) x_npc[i] = vec - RB + vec_base;
                  else             x_npc[i] = vec;
               end
               tg = !qual ? "R10" : (lv > 1) ? "R3" : "R6";
               chk("R2", "taken", 256'(taken[i]), 256'(qual));
               chk(tg, "epc", 256'(epc_o[i]), 256'(x_epc[i]));
               chk(!qual ? "R10" : "R3", "eps", 256'(eps_o[i]), 256'(x_eps[i]));
               chk(!qual ? "R10" : "R5", "depc", 256'(depc_o[i]), 256'(x_depc[i]));
               chk(!qual ? "R10" : (lv > 1) ? "R3" : "R7", "status",
                   256'(st_o[i]), 256'(x_st[i]));
               chk(!qual ? "R10" : "R4", "cause", 256'(cause_o[i]), 256'(x_cause[i]));
               chk(!qual ? "R10" : (x_kind[i] == 2'd3) ? "R5" : "R6", "kind",
                   256'(kind_o[i]), 256'(x_kind[i]));
               chk(!qual ? "R10" : "R9", "redirect", 256'(redir_o[i]), 256'(x_redir[i]));
               chk(!qual ? "R10" : "R8", "next_pc", 256'(npc_o[i]), 256'(x_npc[i]));
            end
            trial++;
         end
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end

endmodule